// File: doc/BRIEF.md
# Serial Audio-Codec Link Output Frame Generator

This block is the controller-side transmitter of a serial audio-codec link. It runs on the bit clock that the codec supplies and drives two lines toward the codec: a frame sync and a serial data line. Every frame is 256 bit clocks long. It opens with a 16-bit tag slot and continues with twelve 20-bit slots. The sync line is high during the tag slot only. With the usual 12.288 MHz bit clock, the frame rate is 48 kHz.

Software, or a higher-level sequencer, writes four parallel slot holding registers: command address, command data, left playback sample and right playback sample. Each register has its own write strobe. A write marks that slot as loaded. At the next frame boundary the generator takes a snapshot of the holding registers and builds the tag from the slots that were loaded. It then shifts the frame out MSB first and pulses a frame-done strobe. Writes made while a frame is being shifted therefore only affect the following frame.

Top module: `codec_link_framer`

## Requirements
- R1: After reset is released, a frame starts on the first rising bit-clock edge. After that, a frame starts every 256 bit clocks.
- R2: `sync` is high for exactly 16 consecutive bit clocks at the start of each frame. It is low for the other 240.
- R3: Serial data lags `sync` by one bit clock. Frame bit position 0 (the tag MSB) is on `sdo` one clock after `sync` rises. Position p follows one clock after position p-1.
- R4: The tag occupies positions 0..15. Position 0 (tag bit 15) is 1 when any slot was loaded for the frame. Positions 1..4 (tag bits 14..11) flag slots 1..4 (command address, command data, left, right) as loaded. Positions 5..15 are 0.
- R5: Slot n (n = 1..12) occupies positions 16+20(n-1) through 35+20(n-1), MSB first. Slot 1 carries `cmd_addr`, slot 2 `cmd_data`, slot 3 `pcm_left` and slot 4 `pcm_right`.
- R6: A slot whose register was not loaded for the frame is sent as 20 zeros, whatever its holding register contains. Slots 5..12 are always zero.
- R7: Slot contents are captured at the frame boundary. A write during a frame does not change that frame. A write on the boundary edge itself goes to the following frame. When a slot is written twice before a boundary, the last value is used.
- R8: Loads are consumed by the frame that carries them. A frame with no writes since the previous boundary has an all-zero tag and all-zero slots.
- R9: `frame_done` is high for exactly one bit clock per frame, in the same cycle as the first high cycle of `sync`.
- R10: While `rst_n` is low, `sync`, `sdo` and `frame_done` are 0 and any pending loads are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock from the codec; everything updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 4 | Per-slot write strobes; bit 0 = slot 1 … bit 3 = slot 4 |
| cmd_addr | input | 20 | Command address for slot 1 |
| cmd_data | input | 20 | Command data for slot 2 |
| pcm_left | input | 20 | Left playback sample for slot 3 |
| pcm_right | input | 20 | Right playback sample for slot 4 |
| sync | output | 1 | Frame sync, high during the tag slot |
| sdo | output | 1 | Serial output data, MSB first |
| frame_done | output | 1 | One-cycle strobe when a new frame is latched |

## Verification
A wrong bit counter shows up at the ports within one frame. Either the `sync` pulse has the wrong length or period, or `frame_done` appears out of step with `sync`. A wrong snapshot or loaded-slot flag shows up in the next transmitted frame as a wrong tag bit or a wrong slot field. The bench therefore captures whole frames and compares them against frames built from its own writes. Stale loads, boundary-edge writes and mid-frame writes each need two consecutive frames to expose: one frame that must be unaffected and one that must carry the write.

// File: rtl/codec_link_framer.sv
module codec_link_framer (
  input  logic        bit_clk,
  input  logic        rst_n,
  input  logic [3:0]  wr_en,
  input  logic [19:0] cmd_addr,
  input  logic [19:0] cmd_data,
  input  logic [19:0] pcm_left,
  input  logic [19:0] pcm_right,
  output logic        sync,
  output logic        sdo,
  output logic        frame_done
);
  localparam int SLOT_W    = 20;
  localparam int TAG_W     = 16;
  localparam int NUM_SLOTS = 13;
  localparam int NUM_LOAD  = 4;
  localparam int FRAME_LEN = TAG_W + (NUM_SLOTS - 1) * SLOT_W;
  localparam int SHIFT_W   = TAG_W + NUM_LOAD * SLOT_W;
  localparam int BODY_W    = NUM_LOAD * SLOT_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);

  logic [CNT_W-1:0]   cnt;
  logic               at_edge;
  logic [NUM_LOAD-1:0] pend;
  logic [SLOT_W-1:0]  slot_in [NUM_LOAD];
  logic [SLOT_W-1:0]  hold    [NUM_LOAD];
  logic [TAG_W-1:0]   tag;
  logic [BODY_W-1:0]  body;
  logic [SHIFT_W-1:0] shreg;

  assign at_edge    = (cnt == '0);
  assign slot_in[0] = cmd_addr;
  assign slot_in[1] = cmd_data;
  assign slot_in[2] = pcm_left;
  assign slot_in[3] = pcm_right;

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n)                             cnt <= '0;
    else if (cnt == CNT_W'(FRAME_LEN - 1))  cnt <= '0;
    else                                    cnt <= cnt + CNT_W'(1);

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n)       pend <= '0;
    else if (at_edge) pend <= wr_en;
    else              pend <= pend | wr_en;

  generate
    for (genvar i = 0; i < NUM_LOAD; i++) begin : g_slot
      always_ff @(posedge bit_clk or negedge rst_n)
        if (!rst_n)         hold[i] <= '0;
        else if (wr_en[i])  hold[i] <= slot_in[i];

      assign tag[TAG_W-2-i] = pend[i];
      assign body[BODY_W-1-i*SLOT_W -: SLOT_W] = pend[i] ? hold[i] : '0;
    end
  endgenerate

  assign tag[TAG_W-1] = |pend;
  assign tag[TAG_W-2-NUM_LOAD:0] = '0;

  always_ff @(posedge bit_clk or negedge rst_n)
    if (!rst_n) begin
      shreg      <= '0;
      sdo        <= 1'b0;
      sync       <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      shreg      <= at_edge ? {tag, body} : {shreg[SHIFT_W-2:0], 1'b0};
      sdo        <= shreg[SHIFT_W-1];
      sync       <= (cnt < CNT_W'(TAG_W));
      frame_done <= at_edge;
    end

  // R2
  sync_width_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $fell(sync) |-> $past(sync, 16));

  // R9
  sync_rise_done_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(sync) |-> frame_done);

  // R6
  idle_tail_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (cnt >= CNT_W'(SHIFT_W + 2) || cnt <= CNT_W'(1)) |-> !sdo);

  // R7
  load_snapshot_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_done |-> (pend == $past(wr_en)));

  // R3
  tag_lag_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(sync) |-> !sdo);
endmodule

// File: tb/test_codec_link_framer.sv
module test_codec_link_framer;
  logic        bit_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  wr_en = '0;
  logic [19:0] cmd_addr = '0, cmd_data = '0, pcm_left = '0, pcm_right = '0;
  logic        sync, sdo, frame_done;

  int checks = 0;
  int fails  = 0;

  always #4 bit_clk = ~bit_clk;

  codec_link_framer i_codec_link_framer (
    .bit_clk(bit_clk), .rst_n(rst_n), .wr_en(wr_en),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .pcm_left(pcm_left), .pcm_right(pcm_right),
    .sync(sync), .sdo(sdo), .frame_done(frame_done));

  // mask[3:0], addr, data, left, right
  localparam logic [83:0] VECS [0:5] = '{
    {4'b1111, 20'h8_0000, 20'h1_2345, 20'hA_BCDE, 20'h5_5AA5},
    {4'b0001, 20'h0_0026, 20'hF_FFFF, 20'hF_FFFF, 20'hF_FFFF},
    {4'b0011, 20'h0_0002, 20'h0_8000, 20'h0_0000, 20'h0_0000},
    {4'b1100, 20'hF_FFFF, 20'hF_FFFF, 20'h7_FFFF, 20'h8_0001},
    {4'b0000, 20'hF_FFFF, 20'hF_FFFF, 20'hF_FFFF, 20'hF_FFFF},
    {4'b1010, 20'h1_1111, 20'hC_0003, 20'h2_2222, 20'hF_000F}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] exp_frame(input logic [3:0] m, input logic [19:0] a,
      input logic [19:0] d, input logic [19:0] l, input logic [19:0] r);
    logic [255:0] f = '0;
    f[255] = |m;
    f[254] = m[0]; f[253] = m[1]; f[252] = m[2]; f[251] = m[3];
    if (m[0]) f[239:220] = a;
    if (m[1]) f[219:200] = d;
    if (m[2]) f[199:180] = l;
    if (m[3]) f[179:160] = r;
    return f;
  endfunction

  task automatic drive(input logic [3:0] m, input logic [19:0] a, input logic [19:0] d,
                       input logic [19:0] l, input logic [19:0] r);
    wr_en = m; cmd_addr = a; cmd_data = d; pcm_left = l; pcm_right = r;
  endtask

  task automatic write_slots(input logic [83:0] v);
    drive(v[83:80], v[79:60], v[59:40], v[39:20], v[19:0]);
    @(negedge bit_clk);
    wr_en = '0;
  endtask

  task automatic wait_done();
    int n = 0;
    do begin
      @(negedge bit_clk);
      n++;
    end while (!frame_done && n < 600);
  endtask

  // Starts at the negedge where frame_done is seen; ends at the next such negedge.
  task automatic capture(input logic [255:0] exp, input string req,
                         input bit mid_en, input logic [83:0] mid_v);
    logic [255:0] got_sdo = '0, got_sync = '0, exp_sync;
    int extra_done = 0;
    exp_sync = {16'hFFFF, 240'h0};
    for (int j = 0; j <= 256; j++) begin
      if (j > 0) @(negedge bit_clk);
      if (j < 256) got_sync[255-j] = sync;
      if (j > 0) got_sdo[255-(j-1)] = sdo;
      if (j > 0 && j < 256 && frame_done) extra_done++;
      if (mid_en && j == 100) drive(mid_v[83:80], mid_v[79:60], mid_v[59:40], mid_v[39:20], mid_v[19:0]);
      if (mid_en && j == 101) wr_en = '0;
    end
    chk(got_sdo[255:240] == exp[255:240], {req, " R4"}, "tag", 256'(got_sdo[255:240]), 256'(exp[255:240]));
    chk(got_sdo[239:0] == exp[239:0], {req, " R5 R6"}, "slots", 256'(got_sdo[239:0]), 256'(exp[239:0]));
    chk(got_sync == exp_sync, "R2 R3", "sync pattern", got_sync, exp_sync);
    chk(extra_done == 0 && frame_done, "R1 R9", "frame_done single/period", 256'(extra_done), 256'(0));
  endtask

  initial begin
    #(8 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge bit_clk);
    chk(!sync && !sdo && !frame_done, "R10", "outputs in reset", 256'({sync, sdo, frame_done}), 256'(0));
    rst_n = 1'b1;
    @(negedge bit_clk);
    chk(frame_done && sync, "R1", "first frame after reset", 256'({frame_done, sync}), 256'(3));
    capture(256'(0), "R8", 1'b0, 84'(0));

    for (int i = 0; i < 6; i++) begin
      logic [83:0] v = VECS[i];
      write_slots(v);
      wait_done();
      capture(exp_frame(v[83:80], v[79:60], v[59:40], v[39:20], v[19:0]), "R5 vec", 1'b0, 84'(0));
    end

    // R8: no writes since last boundary
    capture(256'(0), "R8 stale", 1'b0, 84'(0));

    // R7: mid-frame write does not alter current frame, lands in the next
    write_slots({4'b1111, 20'h1_0001, 20'h2_0002, 20'h3_0003, 20'h4_0004});
    wait_done();
    capture(exp_frame(4'b1111, 20'h1_0001, 20'h2_0002, 20'h3_0003, 20'h4_0004), "R7 mid",
            1'b1, {4'b0100, 20'h0, 20'h0, 20'hB_EEF1, 20'h0});
    capture(exp_frame(4'b0100, 20'h0, 20'h0, 20'hB_EEF1, 20'h0), "R7 next", 1'b0, 84'(0));

    // R7: last write wins
    write_slots({4'b0001, 20'hA_AAAA, 20'h0, 20'h0, 20'h0});
    write_slots({4'b0001, 20'h0_5A5A, 20'h0, 20'h0, 20'h0});
    wait_done();
    capture(exp_frame(4'b0001, 20'h0_5A5A, 20'h0, 20'h0, 20'h0), "R7 last", 1'b0, 84'(0));

    // R7: write on the boundary edge goes to the following frame
    repeat (255) @(negedge bit_clk);
    drive(4'b0010, 20'h0, 20'hD_00D5, 20'h0, 20'h0);
    @(negedge bit_clk);
    wr_en = '0;
    capture(256'(0), "R7 edge-now", 1'b0, 84'(0));
    capture(exp_frame(4'b0010, 20'h0, 20'hD_00D5, 20'h0, 20'h0), "R7 edge-next", 1'b0, 84'(0));

    // R10: reset mid-frame discards pending loads
    write_slots({4'b1111, 20'hF_FFFF, 20'hF_FFFF, 20'hF_FFFF, 20'hF_FFFF});
    repeat (40) @(negedge bit_clk);
    rst_n = 1'b0;
    @(negedge bit_clk);
    chk(!sync && !sdo && !frame_done, "R10", "outputs in mid reset", 256'({sync, sdo, frame_done}), 256'(0));
    rst_n = 1'b1;
    @(negedge bit_clk);
    chk(frame_done, "R1", "restart after reset", 256'(frame_done), 256'(1));
    capture(256'(0), "R10 pend cleared", 1'b0, 84'(0));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule